// File: doc/BRIEF.md
# Common Interrupt Distribution Unit

This block takes a set of shared interrupt inputs and delivers each of them to one or more processor cores. Every shared input has its own destination bitmap with one bit per core, a trigger type (rising edge or active-high level), a distribution policy, a mask bit and an acknowledge command. A single unit-wide enable gates every output. The block drives one line per shared interrupt per core, so each core's local controller sees a private copy of every shared source.

Software programs and inspects the unit through a single command port. A command carries an operation code, the index of the shared interrupt it applies to, and a data word. Read operations put their result on a readback register. The trigger type and the distribution policy share one packed mode word, so software can read the word, change one field and write it back. Under the rotating policy, each new assertion of an interrupt goes to the next core in its destination set, which spreads the load across the set.

Top module: `cirq_distributor`

## Requirements
- R1: After reset every interrupt is masked (mask reads 1), the unit is disabled, every destination and mode word reads 0, and all outputs are low. The first rotating delivery of an interrupt after reset goes to the lowest-numbered core in its destination set.
- R2: Operation codes on `cmd_op` are: 0 unit enable (data bit 0), 1 set destination, 2 set mode, 3 set mask (data bit 0), 4 acknowledge, 5 read mode, 6 read destination, 7 read mask. Writes take effect at the clock edge that samples the command.
- R3: The mode word holds the distribution policy in bits [1:0] and the trigger type in bit 4 (0 rising edge, 1 active-high level). All other bits are not stored and read as 0. A read command loads `rd_data` at its clock edge: the mode word, the destination bitmap in bits [NUM_CORE-1:0], or the mask in bit 0. Every other bit reads 0.
- R4: In edge mode, a rising edge on an input sets a pending state. The pending state is visible on the outputs after that clock edge and is held until an acknowledge command clears it. An input that stays high after the acknowledge does not set it again.
- R5: In level mode, the pending state follows the input with one register stage, and acknowledge has no effect.
- R6: Policy codes 00, 10 and 11 deliver an active interrupt to every core in its destination bitmap at once.
- R7: Policy code 01 (rotating) delivers to exactly one core. Each time an interrupt becomes active, it goes to the next set destination bit after the last core served, wrapping from the top core back to core 0. The choice is held while the interrupt stays active. With an empty bitmap nothing is delivered and the rotation point does not move.
- R8: A masked interrupt drives no output, but its edge pending state is kept. Unmasking releases it.
- R9: While the unit is disabled all outputs are low, but edge pending state is kept. Enabling the unit releases it.
- R10: Commands whose interrupt index is NUM_IRQ or higher change no state, and reads with such an index return 0.
- R11: The line for interrupt i and core c is `core_irq[i*NUM_CORE + c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Operation code (R2) |
| cmd_irq | input | IRQ_W | Index of the shared interrupt the command applies to |
| cmd_data | input | DATA_W | Command data word |
| rd_data | output | DATA_W | Readback register, loaded by read commands |
| irq_in | input | NUM_IRQ | Shared interrupt inputs, active high |
| core_irq | output | NUM_IRQ*NUM_CORE | Per-core delivery lines (R11) |

## Verification
The assertions check four properties on every cycle: a disabled unit keeps every line low, a masked interrupt keeps its lines low, a rotating interrupt never drives two cores at once, and an edge pending state stays set until it is acknowledged and clears when it is. An out-of-range command leaving the configuration unchanged is also checked on every cycle. Which core receives a delivery, the rotation order with its wrap-around, the fields of the mode word on readback, and the release of held pending state when the unit is enabled or an interrupt is unmasked can only be shown by the bench. The bench does this by sweeping every destination bitmap on every interrupt and comparing the outputs against a reference model of the rotation.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

  typedef enum logic [2:0] {
    OP_ENABLE   = 3'd0,
    OP_SET_DEST = 3'd1,
    OP_SET_MODE = 3'd2,
    OP_SET_MASK = 3'd3,
    OP_ACK      = 3'd4,
    OP_RD_MODE  = 3'd5,
    OP_RD_DEST  = 3'd6,
    OP_RD_MASK  = 3'd7
  } cirq_op_e;

  // field positions inside the packed mode word
  localparam int MODE_POL_LSB  = 0;
  localparam int MODE_TRIG_BIT = 4;

  localparam logic [1:0] POL_ROTATE = 2'b01;

endpackage

// File: rtl/cirq_cfg.sv
module cirq_cfg
  import cirq_pkg::*;
#(
  parameter int NUM_IRQ  = 6,
  parameter int NUM_CORE = 4,
  parameter int IRQ_W    = 3,
  parameter int DATA_W   = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_valid,
  input  logic [2:0]                         cmd_op,
  input  logic [IRQ_W-1:0]                   cmd_irq,
  input  logic [DATA_W-1:0]                  cmd_data,
  output logic                               unit_en,
  output logic [NUM_IRQ-1:0][NUM_CORE-1:0]   dest,
  output logic [NUM_IRQ-1:0]                 mask,
  output logic [NUM_IRQ-1:0]                 level_mode,
  output logic [NUM_IRQ-1:0]                 rot_mode,
  output logic [NUM_IRQ-1:0]                 ack,
  output logic [DATA_W-1:0]                  rd_data
);

  cirq_op_e op;
  assign op = cirq_op_e'(cmd_op);

  logic                             en_q,    en_d;
  logic [NUM_IRQ-1:0][NUM_CORE-1:0] dest_q,  dest_d;
  logic [NUM_IRQ-1:0]               mask_q,  mask_d;
  logic [NUM_IRQ-1:0][1:0]          pol_q,   pol_d;
  logic [NUM_IRQ-1:0]               lvl_q,   lvl_d;
  logic [DATA_W-1:0]                rd_q,    rd_d;
  logic                             is_read;

  assign is_read = (op == OP_RD_MODE) || (op == OP_RD_DEST) || (op == OP_RD_MASK);

  // next-state logic
  always_comb begin
    en_d   = en_q;
    dest_d = dest_q;
    mask_d = mask_q;
    pol_d  = pol_q;
    lvl_d  = lvl_q;
    rd_d   = rd_q;
    ack    = '0;
    if (cmd_valid) begin
      if (op == OP_ENABLE) en_d = cmd_data[0];
      if (is_read) rd_d = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (int'(cmd_irq) == i) begin
          case (op)
            OP_SET_DEST: dest_d[i] = cmd_data[NUM_CORE-1:0];
            OP_SET_MODE: begin
              pol_d[i] = cmd_data[MODE_POL_LSB +: 2];
              lvl_d[i] = cmd_data[MODE_TRIG_BIT];
            end
            OP_SET_MASK: mask_d[i] = cmd_data[0];
            OP_ACK:      ack[i] = 1'b1;
            OP_RD_MODE: begin
              rd_d[MODE_POL_LSB +: 2] = pol_q[i];
              rd_d[MODE_TRIG_BIT]     = lvl_q[i];
            end
            OP_RD_DEST:  rd_d[NUM_CORE-1:0] = dest_q[i];
            OP_RD_MASK:  rd_d[0] = mask_q[i];
            default: ;
          endcase
        end
      end
    end
  end

  // state registers, enabled by the command strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dest_q <= '0;
      mask_q <= '1;
      pol_q  <= '0;
      lvl_q  <= '0;
      rd_q   <= '0;
    end else if (cmd_valid) begin
      en_q   <= en_d;
      dest_q <= dest_d;
      mask_q <= mask_d;
      pol_q  <= pol_d;
      lvl_q  <= lvl_d;
      rd_q   <= rd_d;
    end
  end

  assign unit_en    = en_q;
  assign dest       = dest_q;
  assign mask       = mask_q;
  assign level_mode = lvl_q;
  assign rd_data    = rd_q;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_rot
    assign rot_mode[g] = (pol_q[g] == POL_ROTATE);
  end

  // R10
  oob_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (int'(cmd_irq) >= NUM_IRQ)) |=>
      ($stable(dest_q) && $stable(mask_q) && $stable(pol_q) && $stable(lvl_q)));

endmodule

// File: rtl/cirq_trigger.sv
module cirq_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic level_mode,
  input  logic ack,
  output logic pend
);

  logic in_q, in_d;
  logic pend_q, pend_d;
  logic rise;

  assign rise = irq_in & ~in_q;

  always_comb begin
    in_d = irq_in;
    if (level_mode) pend_d = irq_in;
    else            pend_d = (pend_q & ~ack) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      in_q   <= in_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && pend_q && !ack) |=> pend_q);

  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && ack && (in_q || !irq_in)) |=> !pend_q);

endmodule

// File: rtl/cirq_router.sv
module cirq_router #(
  parameter int NUM_CORE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pend,
  input  logic                unit_en,
  input  logic                mask,
  input  logic                rot_mode,
  input  logic [NUM_CORE-1:0] dest,
  output logic [NUM_CORE-1:0] core_out
);

  localparam int CORE_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;
  localparam logic [CORE_W-1:0] LAST_RST = CORE_W'(NUM_CORE - 1);

  logic              act, prev_q, prev_d, new_evt;
  logic [CORE_W-1:0] last_q, last_d, nxt, served;
  logic [NUM_CORE-1:0] sel;

  assign act     = pend & unit_en & ~mask;
  assign new_evt = act & ~prev_q;

  // next set destination bit after the last core served, wrapping
  always_comb begin
    int  idx;
    logic found;
    nxt   = last_q;
    found = 1'b0;
    for (int k = 1; k <= NUM_CORE; k++) begin
      idx = (int'(last_q) + k) % NUM_CORE;
      if (!found && dest[idx]) begin
        nxt   = CORE_W'(idx);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    served      = new_evt ? nxt : last_q;
    sel         = '0;
    sel[served] = 1'b1;
    if (!act)          core_out = '0;
    else if (rot_mode) core_out = sel & dest;
    else               core_out = dest;
    prev_d = act;
    last_d = (new_evt && rot_mode) ? nxt : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      last_q <= LAST_RST;
    end else begin
      prev_q <= prev_d;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/cirq_distributor.sv
module cirq_distributor
  import cirq_pkg::*;
#(
  parameter int NUM_IRQ  = 6,
  parameter int NUM_CORE = 4,
  parameter int IRQ_W    = 3,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_op,
  input  logic [IRQ_W-1:0]             cmd_irq,
  input  logic [DATA_W-1:0]            cmd_data,
  output logic [DATA_W-1:0]            rd_data,
  input  logic [NUM_IRQ-1:0]           irq_in,
  output logic [NUM_IRQ*NUM_CORE-1:0]  core_irq
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_s2, sys_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign sys_rst_n = rst_s2;

  logic                             unit_en;
  logic [NUM_IRQ-1:0][NUM_CORE-1:0] dest;
  logic [NUM_IRQ-1:0]               mask, level_mode, rot_mode, ack, pend;

  cirq_cfg #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_CORE(NUM_CORE),
    .IRQ_W   (IRQ_W),
    .DATA_W  (DATA_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_irq   (cmd_irq),
    .cmd_data  (cmd_data),
    .unit_en   (unit_en),
    .dest      (dest),
    .mask      (mask),
    .level_mode(level_mode),
    .rot_mode  (rot_mode),
    .ack       (ack),
    .rd_data   (rd_data)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    cirq_trigger u_trig (
      .clk       (clk),
      .rst_n     (sys_rst_n),
      .irq_in    (irq_in[i]),
      .level_mode(level_mode[i]),
      .ack       (ack[i]),
      .pend      (pend[i])
    );

    cirq_router #(.NUM_CORE(NUM_CORE)) u_route (
      .clk     (clk),
      .rst_n   (sys_rst_n),
      .pend    (pend[i]),
      .unit_en (unit_en),
      .mask    (mask[i]),
      .rot_mode(rot_mode[i]),
      .dest    (dest[i]),
      .core_out(core_irq[i*NUM_CORE +: NUM_CORE])
    );

    // R8
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      mask[i] |-> (core_irq[i*NUM_CORE +: NUM_CORE] == '0));

    // R7
    rot_single_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      rot_mode[i] |-> $onehot0(core_irq[i*NUM_CORE +: NUM_CORE]));
  end

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !unit_en |-> (core_irq == '0));

endmodule

// File: tb/sim_cirq_distributor.sv
`timescale 1ns/1ps
module sim_cirq_distributor;
  import cirq_pkg::*;

  localparam int NI = 6;
  localparam int NC = 4;
  localparam int IW = 3;
  localparam int DW = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid;
  logic [2:0]        cmd_op;
  logic [IW-1:0]     cmd_irq;
  logic [DW-1:0]     cmd_data;
  logic [DW-1:0]     rd_data;
  logic [NI-1:0]     irq_in;
  logic [NI*NC-1:0]  core_irq;

  int errs = 0;
  int checks = 0;
  int last_m [NI];
  bit done = 0;

  always #4 clk = ~clk;

  cirq_distributor #(.NUM_IRQ(NI), .NUM_CORE(NC), .IRQ_W(IW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_irq(cmd_irq), .cmd_data(cmd_data), .rd_data(rd_data),
    .irq_in(irq_in), .core_irq(core_irq)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_cmd(logic [2:0] op, int irq, logic [31:0] data);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_irq   = IW'(irq);
    cmd_data  = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = '0;
  endtask

  task automatic rd(logic [2:0] op, int irq, output logic [31:0] v);
    do_cmd(op, irq, 32'h0);
    v = rd_data;
  endtask

  function automatic logic [NI*NC-1:0] place(int i, logic [NC-1:0] v);
    logic [NI*NC-1:0] r;
    r = '0;
    r[i*NC +: NC] = v;
    return r;
  endfunction

  function automatic int rot_next(int i, logic [NC-1:0] d);
    for (int k = 1; k <= NC; k++) begin
      if (d[(last_m[i] + k) % NC]) return (last_m[i] + k) % NC;
    end
    return last_m[i];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int e;
    cmd_valid = 0; cmd_op = 0; cmd_irq = 0; cmd_data = 0; irq_in = 0;
    for (int i = 0; i < NI; i++) last_m[i] = NC - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 outputs idle", core_irq, 0);
    for (int i = 0; i < NI; i++) begin
      rd(OP_RD_MASK, i, v); chk("R1 mask set", v, 1);
      rd(OP_RD_DEST, i, v); chk("R1 dest zero", v, 0);
      rd(OP_RD_MODE, i, v); chk("R1 mode zero", v, 0);
    end

    // R9 global enable gates outputs, keeps pending
    do_cmd(OP_SET_MASK, 0, 0);
    do_cmd(OP_SET_DEST, 0, 32'h5);
    irq_in[0] = 1; @(negedge clk); irq_in[0] = 0; @(negedge clk);
    chk("R9 disabled unit quiet", core_irq, 0);
    do_cmd(OP_ENABLE, 0, 1);
    chk("R9 enable releases pending", core_irq, place(0, 4'h5));
    do_cmd(OP_ENABLE, 0, 0);
    chk("R9 disable quiets", core_irq, 0);
    do_cmd(OP_ENABLE, 0, 1);
    chk("R9 re-enable", core_irq, place(0, 4'h5));
    do_cmd(OP_ACK, 0, 0);
    chk("R4 ack clears", core_irq, 0);

    // R2 R3 mode word and readback
    do_cmd(OP_SET_MODE, 3, 32'hFFFF_FFFF);
    rd(OP_RD_MODE, 3, v); chk("R3 mode only fields stored", v, 32'h13);
    do_cmd(OP_SET_MODE, 3, 32'h10);
    rd(OP_RD_MODE, 3, v); chk("R3 trigger field alone", v, 32'h10);
    do_cmd(OP_SET_DEST, 3, 32'hFFFF_FFFF);
    rd(OP_RD_DEST, 3, v); chk("R3 dest width", v, 32'hF);
    rd(OP_RD_DEST, 0, v); chk("R2 dest written", v, 32'h5);
    do_cmd(OP_SET_MODE, 3, 0);
    do_cmd(OP_SET_DEST, 3, 0);

    // R10 out-of-range index
    do_cmd(OP_SET_MASK, 6, 0);
    do_cmd(OP_SET_DEST, 7, 32'hF);
    do_cmd(OP_SET_MODE, 6, 32'h11);
    for (int i = 0; i < NI; i++) begin
      rd(OP_RD_MASK, i, v); chk("R10 masks untouched", v, (i == 0) ? 1'b0 : 1'b1);
      rd(OP_RD_MODE, i, v); chk("R10 modes untouched", v, 0);
    end
    rd(OP_RD_MASK, 6, v); chk("R10 oob read zero", v, 0);
    rd(OP_RD_DEST, 7, v); chk("R10 oob read zero", v, 0);

    // R8 mask
    do_cmd(OP_SET_DEST, 1, 32'hC);
    irq_in[1] = 1; @(negedge clk); irq_in[1] = 0; @(negedge clk);
    chk("R8 masked quiet", core_irq, 0);
    do_cmd(OP_SET_MASK, 1, 0);
    chk("R8 unmask releases", core_irq, place(1, 4'hC));
    do_cmd(OP_SET_MASK, 1, 1);
    chk("R8 mask again", core_irq, 0);
    do_cmd(OP_SET_MASK, 1, 0);
    chk("R8 unmask again", core_irq, place(1, 4'hC));
    do_cmd(OP_ACK, 1, 0);
    chk("R4 ack clears", core_irq, 0);

    // R6 R11 broadcast sweep over every destination bitmap
    for (int i = 0; i < NI; i++) do_cmd(OP_SET_MASK, i, 0);
    for (int i = 0; i < NI; i++) begin
      for (int d = 0; d < 16; d++) begin
        do_cmd(OP_SET_DEST, i, 32'(d));
        irq_in[i] = 1; @(negedge clk);
        chk("R6 R11 broadcast lines", core_irq, place(i, 4'(d)));
        do_cmd(OP_ACK, i, 0);
        chk("R4 no relatch while high", core_irq, 0);
        irq_in[i] = 0; @(negedge clk);
      end
      for (int m = 2; m < 4; m++) begin
        do_cmd(OP_SET_MODE, i, 32'(m));
        do_cmd(OP_SET_DEST, i, 32'hB);
        irq_in[i] = 1; @(negedge clk);
        chk("R6 codes 10 11 broadcast", core_irq, place(i, 4'hB));
        do_cmd(OP_ACK, i, 0);
        irq_in[i] = 0; @(negedge clk);
      end
      do_cmd(OP_SET_MODE, i, 0);
    end

    // R4 edge pending held
    do_cmd(OP_SET_DEST, 2, 32'h3);
    irq_in[2] = 1; @(negedge clk); irq_in[2] = 0;
    repeat (5) @(negedge clk);
    chk("R4 pending held", core_irq, place(2, 4'h3));
    do_cmd(OP_ACK, 2, 0);
    chk("R4 ack clears", core_irq, 0);

    // R5 level mode
    do_cmd(OP_SET_MODE, 2, 32'h10);
    do_cmd(OP_SET_DEST, 2, 32'h6);
    irq_in[2] = 1; @(negedge clk);
    chk("R5 level asserted", core_irq, place(2, 4'h6));
    do_cmd(OP_ACK, 2, 0);
    chk("R5 ack ignored", core_irq, place(2, 4'h6));
    irq_in[2] = 0; @(negedge clk);
    chk("R5 level follows input", core_irq, 0);

    // R1 first rotating delivery goes to lowest set bit
    do_cmd(OP_SET_MODE, 5, 32'h1);
    do_cmd(OP_SET_DEST, 5, 32'h6);
    irq_in[5] = 1; @(negedge clk);
    chk("R1 first rotation lowest bit", core_irq, place(5, 4'h2));
    last_m[5] = 1;
    do_cmd(OP_ACK, 5, 0);
    irq_in[5] = 0; @(negedge clk);

    // R7 rotation sweep, edge trigger
    for (int i = 0; i < NI; i++) begin
      do_cmd(OP_SET_MODE, i, 32'h1);
      for (int d = 0; d < 16; d++) begin
        do_cmd(OP_SET_DEST, i, 32'(d));
        for (int n = 0; n < 5; n++) begin
          e = rot_next(i, 4'(d));
          irq_in[i] = 1; @(negedge clk);
          chk("R7 rotation target", core_irq, (d == 0) ? '0 : place(i, 4'(1 << e)));
          @(negedge clk);
          chk("R7 choice held", core_irq, (d == 0) ? '0 : place(i, 4'(1 << e)));
          last_m[i] = e;
          do_cmd(OP_ACK, i, 0);
          irq_in[i] = 0; @(negedge clk);
        end
      end
    end

    // R7 rotation with level trigger
    do_cmd(OP_SET_MODE, 4, 32'h11);
    do_cmd(OP_SET_DEST, 4, 32'hD);
    for (int n = 0; n < 6; n++) begin
      e = rot_next(4, 4'hD);
      irq_in[4] = 1; @(negedge clk);
      chk("R7 level rotation", core_irq, place(4, 4'(1 << e)));
      last_m[4] = e;
      irq_in[4] = 0; @(negedge clk);
      chk("R7 level release", core_irq, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule